// File: doc/BRIEF.md
# Network Controller Command Sequencer

This block holds the single 8-bit command byte through which a host steers a packet network controller. The byte carries a run/halt pair, a transmit request, a three-bit remote DMA command and a two-bit register page index. The block does more than store the byte. It works out when each written value actually takes effect, and it drops or holds values that the overlap rules forbid.

A halt request waits until any receive or transmit activity has drained. Only then does the block report that the controller has gone off-line. A transmit request starts one transmission and stays pending until the transmit engine reports that the transmission finished or was abandoned. Remote DMA commands start a read, write or send-packet transfer, abort it, or complete at once when no bytes are left to move. The MAC, the buffer memory and the DMA datapath are outside the block. It sees them only through busy, done and count-zero handshake inputs.

Top module: `nic_cmd_sequencer`

## Requirements
- R1: After reset the readback is 0x21: halt bit 1, run bit 0, transmit bit 0, DMA field 100. The page index is 0, the DMA mode is idle (0) and the off-line flag is 1.
- R2: The readback layout is halt in bit 0, run in bit 1, transmit in bit 2, DMA command in bits 5:3 and page in bits 7:6. Every output changes on the clock edge that samples the write.
- R3: After the halt bit is 1, the off-line flag rises on the first edge at which both tx_busy and rx_busy are low. It stays low while either of them is high.
- R4: A write with halt 0 and run 1 clears the off-line flag on that edge. No other write clears it.
- R5: A write with halt 1 sets the halt bit and leaves the run bit set if it was already set. A write with halt 0 loads the run bit from the data.
- R6: Bit 2 written as 1 is accepted only when the same write has halt 0 and run 1 and no transmit is pending. On acceptance the transmit bit reads 1 and tx_go pulses high for exactly one cycle.
- R7: A pending transmit bit clears on the edge that samples tx_done or tx_abort. Writing 0 to bit 2 does not clear it.
- R8: While idle and with rdma_cnt_zero low, DMA codes 001, 010 and 011 start a remote read, a remote write and a send-packet. rdma_mode then shows 1, 2 and 3 respectively. Code 000 is ignored and the field keeps its value.
- R9: Any DMA code with bit 5 set is stored as written and makes the mode idle. If a transfer was active, rdma_abort pulses for one cycle.
- R10: While a transfer is active, any non-abort DMA code is ignored. Mode and field are left unchanged.
- R11: A start code written while idle with rdma_cnt_zero high completes at once. The mode stays idle and the field reads back the code with bit 5 set.
- R12: An active transfer that sees rdma_cnt_zero high returns to idle on that edge. Its field then reads back with bit 5 set.
- R13: Bits 7:6 are stored on every write whatever the other bits hold, and drive page_sel. Code 3 is passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe for the command byte |
| wr_data | input | 8 | Host write data |
| tx_busy | input | 1 | Transmit engine has a frame in flight |
| rx_busy | input | 1 | Receive engine has a frame in flight |
| tx_done | input | 1 | Pulse: transmission completed |
| tx_abort | input | 1 | Pulse: transmission abandoned |
| rdma_cnt_zero | input | 1 | Remote byte count is zero |
| rd_data | output | 8 | Command byte readback |
| page_sel | output | 2 | Current register page index |
| tx_go | output | 1 | One-cycle pulse starting a transmission |
| rdma_mode | output | 2 | 0 idle, 1 read, 2 write, 3 send packet |
| rdma_abort | output | 1 | One-cycle pulse when an active transfer is aborted |
| rst_done | output | 1 | Controller is in the off-line state |

## Verification
The hardest cases involve overlap in time between host writes and engine activity. One is a halt written while a frame is still draining. Another is a write-direction command arriving while a read transfer is still running. The stimulus holds rx_busy and tx_busy high across several cycles after the halt write, then releases them one at a time. It also keeps rdma_cnt_zero low so that a transfer stays active while conflicting, repeated and abort codes are written into it. A behavioural model runs beside the design and is compared against it on every clock.

// File: rtl/nic_cmd_pkg.sv
// Package: shared field positions and DMA mode encoding for the command sequencer.
// Assumes an 8-bit command byte whose bit positions are fixed by the host software.
package nic_cmd_pkg;
    localparam int CMD_W      = 8;
    localparam int BIT_HALT   = 0;
    localparam int BIT_RUN    = 1;
    localparam int BIT_TX     = 2;
    localparam int DMA_LSB    = 3;
    localparam int DMA_W      = 3;
    localparam int PAGE_LSB   = 6;
    localparam int PAGE_W     = 2;
    localparam int MODE_W     = 2;

    typedef enum logic [MODE_W-1:0] {
        RDMA_IDLE  = 2'd0,
        RDMA_READ  = 2'd1,
        RDMA_WRITE = 2'd2,
        RDMA_SEND  = 2'd3
    } rdma_mode_e;

    localparam logic [DMA_W-1:0] DMA_FIELD_RST = 3'b100;
endpackage

// File: rtl/cmd_runstate.sv
// Module: run/halt state and off-line flag.
// Tracks the halt and run bits. The off-line flag is raised only after the halt bit
// is set and both engines report idle. Assumes the busy inputs are synchronous to clk.
module cmd_runstate (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_halt,
    input  logic wr_run,
    input  logic tx_busy,
    input  logic rx_busy,
    output logic halt_q,
    output logic run_q,
    output logic offline_q
);
    logic drained;
    logic resume_wr;

    // Engines are quiet and nothing is in flight.
    assign drained   = !tx_busy && !rx_busy;
    // A write that leaves the off-line state.
    assign resume_wr = wr_en && !wr_halt && wr_run;

    // Capture halt/run; a halt keeps an already set run bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b1;
            run_q  <= 1'b0;
        end else if (wr_en) begin
            halt_q <= wr_halt;
            run_q  <= wr_halt ? (run_q | wr_run) : wr_run;
        end
    end

    // Off-line flag: cleared by a resume write, set once halted and drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offline_q <= 1'b1;
        end else if (resume_wr) begin
            offline_q <= 1'b0;
        end else if (halt_q && drained) begin
            offline_q <= 1'b1;
        end
    end

    AST_OFFLINE_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(offline_q) |-> $past(halt_q && !tx_busy && !rx_busy)); // R3
    AST_OFFLINE_CLEAR_BY_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(offline_q) |-> $past(wr_en && !wr_halt && wr_run)); // R4
    AST_HALT_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_halt && run_q) |=> run_q); // R5
endmodule

// File: rtl/cmd_txreq.sv
// Module: transmit request bit and start strobe.
// A request is accepted only from a write that also runs the controller, and only
// while no request is pending. The bit self-clears on done or abort from the engine.
module cmd_txreq (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_tx,
    input  logic run_ok,
    input  logic tx_done,
    input  logic tx_abort,
    output logic txp_q,
    output logic tx_go_q
);
    logic accept;
    logic finish;

    // A new transmit request is taken.
    assign accept = wr_en && wr_tx && run_ok && !txp_q;
    // The engine has ended the current transmission.
    assign finish = txp_q && (tx_done || tx_abort);

    // Pending bit: an end report wins over a new request; writing 0 does nothing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txp_q <= 1'b0;
        end else if (finish) begin
            txp_q <= 1'b0;
        end else if (accept) begin
            txp_q <= 1'b1;
        end
    end

    // One-cycle start strobe towards the transmit engine.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_go_q <= 1'b0;
        else        tx_go_q <= accept;
    end

    AST_TXGO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_go_q |=> !tx_go_q); // R6
    AST_TXGO_WITH_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        tx_go_q |-> txp_q); // R6
    AST_TXP_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (txp_q && (tx_done || tx_abort)) |=> !txp_q); // R7
endmodule

// File: rtl/cmd_rdma.sv
// Module: remote DMA command field and transfer mode.
// Starts, aborts and completes remote transfers. Assumes rdma_cnt_zero is a level
// from the external byte counter. Address handling lives outside this block and an
// abort does not rewind it.
module cmd_rdma
    import nic_cmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [DMA_W-1:0]    wr_cmd,
    input  logic                cnt_zero,
    output logic [DMA_W-1:0]    field_q,
    output rdma_mode_e          mode_q,
    output logic                abort_q
);
    logic wr_abort;
    logic wr_start;
    logic active;

    // A write carrying the abort/complete code.
    assign wr_abort = wr_en && wr_cmd[DMA_W-1];
    // A write carrying one of the three start codes.
    assign wr_start = wr_en && !wr_cmd[DMA_W-1] && (wr_cmd != '0);
    // A transfer is running.
    assign active   = (mode_q != RDMA_IDLE);

    // Field and mode update: abort, then count-zero completion, then idle start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_q <= DMA_FIELD_RST;
            mode_q  <= RDMA_IDLE;
        end else if (wr_abort) begin
            field_q <= wr_cmd;
            mode_q  <= RDMA_IDLE;
        end else if (active && cnt_zero) begin
            field_q <= {1'b1, field_q[DMA_W-2:0]};
            mode_q  <= RDMA_IDLE;
        end else if (wr_start && !active) begin
            if (cnt_zero) begin
                field_q <= {1'b1, wr_cmd[DMA_W-2:0]};
            end else begin
                field_q <= wr_cmd;
                mode_q  <= rdma_mode_e'(wr_cmd[MODE_W-1:0]);
            end
        end
    end

    // Abort strobe only when a running transfer is cut short.
    always_ff @(posedge clk) begin
        if (!rst_n) abort_q <= 1'b0;
        else        abort_q <= wr_abort && active;
    end

    AST_ABORT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_q |-> (mode_q == RDMA_IDLE)); // R9
    AST_NO_DIRECT_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != RDMA_IDLE) |=> ((mode_q == $past(mode_q)) || (mode_q == RDMA_IDLE))); // R10
    AST_COUNT_ZERO_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q != RDMA_IDLE) && cnt_zero) |=> ((mode_q == RDMA_IDLE) && field_q[DMA_W-1])); // R12
    AST_IDLE_FIELD_HAS_END: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == RDMA_IDLE) |-> (field_q[DMA_W-1] || (field_q == '0))); // R11
endmodule

// File: rtl/nic_cmd_sequencer.sv
// Module: top of the command sequencer.
// Splits the host byte into its fields and hands them to the run-state, transmit and
// remote DMA sequencers. Holds the page index and assembles the readback.
// Assumes a single host writer and handshake inputs synchronous to clk.
module nic_cmd_sequencer
    import nic_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic        tx_busy,
    input  logic        rx_busy,
    input  logic        tx_done,
    input  logic        tx_abort,
    input  logic        rdma_cnt_zero,
    output logic [7:0]  rd_data,
    output logic [1:0]  page_sel,
    output logic        tx_go,
    output logic [1:0]  rdma_mode,
    output logic        rdma_abort,
    output logic        rst_done
);
    logic               halt_q;
    logic               run_q;
    logic               txp_q;
    logic [DMA_W-1:0]   dma_field;
    rdma_mode_e         dma_mode;
    logic [PAGE_W-1:0]  page_q;
    logic               run_ok;

    // The same write must release halt and assert run for a transmit to be taken.
    assign run_ok = !wr_data[BIT_HALT] && wr_data[BIT_RUN];

    cmd_runstate u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_halt   (wr_data[BIT_HALT]),
        .wr_run    (wr_data[BIT_RUN]),
        .tx_busy   (tx_busy),
        .rx_busy   (rx_busy),
        .halt_q    (halt_q),
        .run_q     (run_q),
        .offline_q (rst_done)
    );

    cmd_txreq u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_tx    (wr_data[BIT_TX]),
        .run_ok   (run_ok),
        .tx_done  (tx_done),
        .tx_abort (tx_abort),
        .txp_q    (txp_q),
        .tx_go_q  (tx_go)
    );

    cmd_rdma u_dma (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_cmd   (wr_data[DMA_LSB +: DMA_W]),
        .cnt_zero (rdma_cnt_zero),
        .field_q  (dma_field),
        .mode_q   (dma_mode),
        .abort_q  (rdma_abort)
    );

    // Page index: taken from every write, no other condition.
    always_ff @(posedge clk) begin
        if (!rst_n)     page_q <= '0;
        else if (wr_en) page_q <= wr_data[PAGE_LSB +: PAGE_W];
    end

    assign page_sel  = page_q;
    assign rdma_mode = dma_mode;
    assign rd_data   = {page_q, dma_field, txp_q, run_q, halt_q};

    AST_PAGE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (page_sel == $past(wr_data[7:6]))); // R13
    AST_READBACK_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[0]) |=> rd_data[0]); // R2
endmodule

// File: tb/nic_cmd_sequencer_tb.sv
module nic_cmd_sequencer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tx_busy = 1'b0;
    logic       rx_busy = 1'b0;
    logic       tx_done = 1'b0;
    logic       tx_abort = 1'b0;
    logic       rdma_cnt_zero = 1'b0;
    logic [7:0] rd_data;
    logic [1:0] page_sel;
    logic       tx_go;
    logic [1:0] rdma_mode;
    logic       rdma_abort;
    logic       rst_done;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;
    bit model_ok = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    logic m_halt, m_run, m_off, m_txp, m_go, m_abt;
    logic [2:0] m_fld;
    int   m_mode;
    logic [1:0] m_pg;

    always #10 clk = ~clk;

    nic_cmd_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tx_busy(tx_busy), .rx_busy(rx_busy), .tx_done(tx_done), .tx_abort(tx_abort),
        .rdma_cnt_zero(rdma_cnt_zero), .rd_data(rd_data), .page_sel(page_sel),
        .tx_go(tx_go), .rdma_mode(rdma_mode), .rdma_abort(rdma_abort), .rst_done(rst_done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // Reference model: follows the requirements each clock.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_halt = 1; m_run = 0; m_off = 1; m_txp = 0; m_go = 0;
            m_abt = 0; m_fld = 3'b100; m_mode = 0; m_pg = 0;
            model_ok = 1'b1;
        end else begin
            logic [2:0] cmd;
            logic acc;
            cmd = wr_data[5:3];
            // R4 / R3
            if (wr_en && !wr_data[0] && wr_data[1]) m_off = 0;
            else if (m_halt && !tx_busy && !rx_busy) m_off = 1;
            // R6 / R7
            acc = wr_en && wr_data[2] && !wr_data[0] && wr_data[1] && !m_txp;
            m_go = acc;
            if (m_txp && (tx_done || tx_abort)) m_txp = 0;
            else if (acc) m_txp = 1;
            // R5
            if (wr_en) begin
                m_run  = wr_data[0] ? (m_run | wr_data[1]) : wr_data[1];
                m_halt = wr_data[0];
                m_pg   = wr_data[7:6];
            end
            // R8 - R12
            m_abt = 0;
            if (wr_en && cmd[2]) begin
                m_abt = (m_mode != 0); m_mode = 0; m_fld = cmd;
            end else if (m_mode != 0 && rdma_cnt_zero) begin
                m_mode = 0; m_fld[2] = 1'b1;
            end else if (wr_en && cmd != 0 && m_mode == 0) begin
                if (rdma_cnt_zero) m_fld = cmd | 3'b100;
                else begin m_mode = cmd; m_fld = cmd; end
            end
        end
    end

    // Compare every cycle, half a period after the edge.
    always @(negedge clk) begin
        if (model_ok && rst_n && !done) begin
            chk({cur_req, "/R2"}, "rd_data", rd_data, {m_pg, m_fld, m_txp, m_run, m_halt});
            chk({cur_req, "/R3"}, "rst_done", rst_done, m_off);
            chk({cur_req, "/R6"}, "tx_go", tx_go, m_go);
            chk({cur_req, "/R8"}, "rdma_mode", rdma_mode, m_mode);
            chk({cur_req, "/R9"}, "rdma_abort", rdma_abort, m_abt);
            chk({cur_req, "/R13"}, "page_sel", page_sel, m_pg);
        end
    end

    task automatic wr(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog
    always @(negedge clk) begin
        if (cycles > 20000 && !done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1", "reset rd_data", rd_data, 8'h21);
        chk("R1", "reset rst_done", rst_done, 1);
        chk("R1", "reset mode", rdma_mode, 0);
        chk("R1", "reset page", page_sel, 0);

        // R4: halt+run leaves it off-line, resume clears
        cur_req = "R4";
        wr(8'h03);
        chk("R4", "halt+run keeps offline", rst_done, 1);
        chk("R5", "run bit set with halt", rd_data[1], 1);
        wr(8'h22);
        chk("R4", "resume clears offline", rst_done, 0);

        // R6 / R7 transmit
        cur_req = "R6";
        @(negedge clk); wr_en = 1; wr_data = 8'h26;
        @(negedge clk); wr_en = 0;
        chk("R6", "tx_go pulse", tx_go, 1);
        chk("R6", "txp bit", rd_data[2], 1);
        @(negedge clk);
        chk("R6", "tx_go one cycle", tx_go, 0);
        wr(8'h26);
        chk("R6", "no second go while pending", tx_go, 0);
        cur_req = "R7";
        wr(8'h22);
        chk("R7", "writing 0 keeps txp", rd_data[2], 1);
        @(negedge clk); tx_done = 1; @(negedge clk); tx_done = 0;
        chk("R7", "txp cleared by done", rd_data[2], 0);
        wr(8'h27);
        chk("R6", "halt write cannot transmit", tx_go, 0);
        wr(8'h26);
        @(negedge clk); tx_abort = 1; @(negedge clk); tx_abort = 0;
        chk("R7", "txp cleared by abort", rd_data[2], 0);

        // R5 / R3 halt while draining
        cur_req = "R3";
        tx_busy = 1; rx_busy = 1;
        wr(8'h21);
        chk("R5", "halt keeps run bit", rd_data[1:0], 2'b11);
        idle(4);
        chk("R3", "still online while busy", rst_done, 0);
        tx_busy = 0; idle(3);
        chk("R3", "still online while rx busy", rst_done, 0);
        rx_busy = 0; @(negedge clk);
        chk("R3", "offline after drain", rst_done, 1);
        wr(8'h22);
        chk("R4", "resume again", rst_done, 0);
        wr(8'h20);
        chk("R5", "run loads 0 without halt", rd_data[1], 0);
        wr(8'h22);

        // R8 - R12 remote DMA
        cur_req = "R8";
        rdma_cnt_zero = 0;
        wr(8'h0A);
        chk("R8", "remote read", rdma_mode, 1);
        cur_req = "R10";
        wr(8'h12);
        chk("R10", "write ignored while read", rdma_mode, 1);
        chk("R10", "field kept", rd_data[5:3], 3'b001);
        wr(8'h1A);
        chk("R10", "send ignored while read", rdma_mode, 1);
        cur_req = "R9";
        @(negedge clk); wr_en = 1; wr_data = 8'h22;
        @(negedge clk); wr_en = 0;
        chk("R9", "abort pulse", rdma_abort, 1);
        chk("R9", "idle after abort", rdma_mode, 0);
        cur_req = "R8";
        wr(8'h12);
        chk("R8", "remote write", rdma_mode, 2);
        cur_req = "R12";
        idle(2);
        rdma_cnt_zero = 1; @(negedge clk);
        chk("R12", "idle on count zero", rdma_mode, 0);
        chk("R12", "field rd2 set", rd_data[5:3], 3'b110);
        chk("R12", "no abort pulse", rdma_abort, 0);
        cur_req = "R11";
        wr(8'h1A);
        chk("R11", "immediate completion", rdma_mode, 0);
        chk("R11", "field 111", rd_data[5:3], 3'b111);
        rdma_cnt_zero = 0;
        cur_req = "R8";
        wr(8'h02);
        chk("R8", "code 000 ignored", rd_data[5:3], 3'b111);
        wr(8'h1A);
        chk("R8", "send packet", rdma_mode, 3);
        wr(8'h32);
        chk("R9", "abort code 110 stored", rd_data[5:3], 3'b110);

        // R13 page select
        cur_req = "R13";
        wr(8'h62);
        chk("R13", "page 1", page_sel, 1);
        wr(8'hA2);
        chk("R13", "page 2", page_sel, 2);
        wr(8'hE3);
        chk("R13", "page 3 passes", page_sel, 3);
        idle(4);
        finish_run();
    end
endmodule